// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block is a small bank of registers that two processors use to pass words and event flags to each other. It is seen here from the side of the I/O processor, which reaches it over a 32-bit register bus. Each bus access is either 32 bits or 16 bits wide. The other processor has its own side port. Through that port it writes its mailbox word, raises flags that the local side later clears, and acknowledges flags that the local side raised.

There are six decoded slots, and each has its own write rule:

| Offset | Slot | Write rule |
|---|---|---|
| 0x00 | inbox | read-only from the local side |
| 0x10 | outbox | stored directly |
| 0x20 | pending flags | write-one-to-clear |
| 0x30 | posted flags | write-one-to-set |
| 0x40 | control | toggles a nibble mask and can force a state nibble |
| 0x60 | clear slot | any write clears it; reads give zero |

Reads of the control word always carry some bits forced to one. Only address bits 11 and 7:4 take part in the decode. All other address bits are ignored.

Top module: `mbox_bank`

## Requirements
- R1: After reset, every stored word is zero. A 32-bit read of control returns 0xF0000002, a 16-bit read of control returns 0x00000002, and every other slot reads zero.
- R2: A pulse on `peer_mbox_we` stores `peer_mbox_data` into the inbox (offset 0x00) at the next clock edge. Local bus writes to offset 0x00 leave the inbox unchanged.
- R3: A local write to offset 0x10 stores the written data into the outbox.
- R4: A local write to offset 0x20 clears each pending-flag bit whose written bit is one. Each one bit in `peer_flag_set` sets that pending-flag bit. If both act on the same bit in the same cycle, the set wins.
- R5: A local write to offset 0x30 sets each posted-flag bit whose written bit is one. Each one bit in `peer_ack_clr` clears that posted-flag bit. If both act on the same bit in the same cycle, the local set wins.
- R6: On a write to control (offset 0x40), if written bit 5 or written bit 7 is one, control bits 15:12 become 4'h2.
- R7: On a write to control, written bits 7:4 form a mask. If any control bit under the mask is already one, all masked bits are cleared. Otherwise all masked bits are set. Control bits 11:8 and 3:0 never change.
- R8: A 32-bit read of control returns the stored word ORed with 0xF0000002. A 16-bit read returns the stored low half ORed with 0x0002, placed in bits 15:0, with bits 31:16 zero.
- R9: A read of offset 0x60 returns zero, including right after a write to it. A write to offset 0x60 changes no other slot.
- R10: The decode uses only address bits 11 and 7:4. An address with bit 11 set, or with bits 7:4 equal to 5 or 7, reads zero and writes nothing. All other address bits are ignored.
- R11: A 16-bit write (`bus_wide`=0) uses only `bus_wdata[15:0]` and leaves bits 31:16 of the addressed slot unchanged. A 16-bit read returns the low half of the slot in `bus_rdata[15:0]`, with the upper half zero.
- R12: Read data is combinational from the current register state while `bus_en`=1 and `bus_wr`=0. At all other times it is zero. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| peer_mbox_we | input | 1 | Other processor writes its inbox word |
| peer_mbox_data | input | 32 | Word for the inbox |
| peer_flag_set | input | 32 | Bits to raise in the pending-flag slot |
| peer_ack_clr | input | 32 | Bits to drop in the posted-flag slot |

## Verification
The assertions assume that `bus_en`, `bus_wr` and `bus_wide` are never unknown while reset is released. They also assume that the side-port masks are held at zero when the other processor has nothing to do. The stimulus meets both assumptions: it drives every input to a defined value at each falling edge, and it returns the side-port inputs to zero after each cycle. The random stimulus lets the side-port masks overlap local flag writes in the same cycle, so the tie-break rules are exercised. It also scatters random bits into the address bits that the decode ignores.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    // decode key = {addr[11], addr[7:4]}
    localparam logic [4:0] KEY_INBOX  = 5'h00;
    localparam logic [4:0] KEY_OUTBOX = 5'h01;
    localparam logic [4:0] KEY_PEND   = 5'h02;
    localparam logic [4:0] KEY_POST   = 5'h03;
    localparam logic [4:0] KEY_CTRL   = 5'h04;
    localparam logic [4:0] KEY_ZERO   = 5'h06;

    localparam logic [DATA_W-1:0] CTRL_OR_WIDE   = 32'hF000_0002;
    localparam logic [HALF_W-1:0] CTRL_OR_NARROW = 16'h0002;
    localparam logic [3:0]        CTRL_FORCE_VAL = 4'h2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INBOX,
        SEL_OUTBOX,
        SEL_PEND,
        SEL_POST,
        SEL_CTRL,
        SEL_ZERO
    } slot_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] inbox;
        logic [DATA_W-1:0] outbox;
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] post;
        logic [DATA_W-1:0] ctrl;
    } bank_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_sel_e         sel
);
    localparam int HI_BIT = 11;

    logic [4:0] key;

    always_comb begin
        key = {addr[HI_BIT], addr[7:4]};
        unique case (key)
            KEY_INBOX:  sel = SEL_INBOX;
            KEY_OUTBOX: sel = SEL_OUTBOX;
            KEY_PEND:   sel = SEL_PEND;
            KEY_POST:   sel = SEL_POST;
            KEY_CTRL:   sel = SEL_CTRL;
            KEY_ZERO:   sel = SEL_ZERO;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wide,
    input  slot_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              peer_mbox_we,
    input  logic [DATA_W-1:0] peer_mbox_data,
    input  logic [DATA_W-1:0] peer_flag_set,
    input  logic [DATA_W-1:0] peer_ack_clr,
    output bank_t             bank_q
);
    bank_t             bank_d;
    logic [DATA_W-1:0] w_mask;
    logic [DATA_W-1:0] tog_mask;
    logic [DATA_W-1:0] ctrl_t;
    logic              hit_pend, hit_post, hit_out, hit_ctrl;

    always_comb begin
        w_mask   = wide ? wdata : {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
        hit_pend = wr_en && (sel == SEL_PEND);
        hit_post = wr_en && (sel == SEL_POST);
        hit_out  = wr_en && (sel == SEL_OUTBOX);
        hit_ctrl = wr_en && (sel == SEL_CTRL);
        tog_mask = {{(DATA_W-8){1'b0}}, wdata[7:4], 4'b0000};
        ctrl_t   = bank_q.ctrl;

        bank_d = bank_q;

        if (peer_mbox_we) bank_d.inbox = peer_mbox_data;

        bank_d.pend = (bank_q.pend & ~(hit_pend ? w_mask : '0)) | peer_flag_set;
        bank_d.post = (bank_q.post & ~peer_ack_clr) | (hit_post ? w_mask : '0);

        if (hit_out)
            bank_d.outbox = wide ? wdata
                                 : {bank_q.outbox[DATA_W-1:HALF_W], wdata[HALF_W-1:0]};

        if (hit_ctrl) begin
            if (wdata[5] || wdata[7]) ctrl_t[15:12] = CTRL_FORCE_VAL;
            if ((ctrl_t & tog_mask) != '0) ctrl_t = ctrl_t & ~tog_mask;
            else                           ctrl_t = ctrl_t | tog_mask;
            bank_d.ctrl = ctrl_t;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // R2
    inbox_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !peer_mbox_we |=> $stable(bank_q.inbox));

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pend && peer_flag_set == '0) |=> ((bank_q.pend & $past(w_mask)) == '0));

    // R5
    post_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_post |=> ((bank_q.post & $past(w_mask)) == $past(w_mask)));

    // R6
    ctrl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctrl && (wdata[5] || wdata[7])) |=> (bank_q.ctrl[15:12] == CTRL_FORCE_VAL));

    // R7
    ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(bank_q.ctrl[11:8]) && $stable(bank_q.ctrl[3:0])));

    // R11
    outbox_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_out && !wide) |=> $stable(bank_q.outbox[DATA_W-1:HALF_W]));
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
    import mbox_pkg::*;
(
    input  logic              rd_en,
    input  logic              wide,
    input  slot_sel_e         sel,
    input  bank_t             bank,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        unique case (sel)
            SEL_INBOX:  raw = bank.inbox;
            SEL_OUTBOX: raw = bank.outbox;
            SEL_PEND:   raw = bank.pend;
            SEL_POST:   raw = bank.post;
            SEL_CTRL:   raw = bank.ctrl | CTRL_OR_WIDE;
            default:    raw = '0;
        endcase

        if (!rd_en)    rdata = '0;
        else if (wide) rdata = raw;
        else           rdata = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              peer_mbox_we,
    input  logic [31:0]       peer_mbox_data,
    input  logic [31:0]       peer_flag_set,
    input  logic [31:0]       peer_ack_clr
);
    slot_sel_e sel;
    bank_t     bank_q;
    logic      wr_en, rd_en;

    assign wr_en = bus_en && bus_wr;
    assign rd_en = bus_en && !bus_wr;

    mbox_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    mbox_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wide           (bus_wide),
        .sel            (sel),
        .wdata          (bus_wdata),
        .peer_mbox_we   (peer_mbox_we),
        .peer_mbox_data (peer_mbox_data),
        .peer_flag_set  (peer_flag_set),
        .peer_ack_clr   (peer_ack_clr),
        .bank_q         (bank_q)
    );

    mbox_rdmux u_rd (
        .rd_en (rd_en),
        .wide  (bus_wide),
        .sel   (sel),
        .bank  (bank_q),
        .rdata (bus_rdata)
    );

    // R8
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr[11] == 1'b0 && bus_addr[7:4] == 4'h4)
        |-> (bus_rdata[1] && (bus_wide ? bus_rdata[31:28] == 4'hF : bus_rdata[31:16] == '0)));

    // R9
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr[11] == 1'b0 && bus_addr[7:4] == 4'h6) |-> (bus_rdata == '0));

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr[11]) |-> (bus_rdata == '0));

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_rdata == '0));
endmodule

// File: tb/mbox_bank_test.sv
`timescale 1ns/1ps
module mbox_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        peer_mbox_we = 1'b0;
    logic [31:0] peer_mbox_data = '0, peer_flag_set = '0, peer_ack_clr = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_in, m_out, m_pend, m_post, m_ctrl;

    always #2.5 clk = ~clk;

    mbox_bank #(.ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .peer_mbox_we(peer_mbox_we),
        .peer_mbox_data(peer_mbox_data), .peer_flag_set(peer_flag_set),
        .peer_ack_clr(peer_ack_clr)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic w);
        logic [31:0] v;
        if (a[11]) v = 32'h0;
        else case (a[7:4])
            4'h0: v = m_in;
            4'h1: v = m_out;
            4'h2: v = m_pend;
            4'h3: v = m_post;
            4'h4: v = m_ctrl | 32'hF000_0002;
            default: v = 32'h0;
        endcase
        return w ? v : {16'h0, v[15:0]};
    endfunction

    function automatic logic [31:0] ctrl_next(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] t, m;
        t = c;
        m = {24'h0, d[7:4], 4'h0};
        if (d[5] | d[7]) t[15:12] = 4'h2;
        if ((t & m) != 0) t = t & ~m;
        else t = t | m;
        return t;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // one cycle: bus access plus side-port activity, model updated after the edge
    task automatic cyc(input logic en, input logic wr, input logic w,
                       input logic [11:0] a, input logic [31:0] d,
                       input logic pwe, input logic [31:0] pdata,
                       input logic [31:0] pset, input logic [31:0] pclr,
                       input string tag);
        logic [31:0] mk;
        @(negedge clk);
        bus_en = en; bus_wr = wr; bus_wide = w; bus_addr = a; bus_wdata = d;
        peer_mbox_we = pwe; peer_mbox_data = pdata;
        peer_flag_set = pset; peer_ack_clr = pclr;
        #1;
        if (en && !wr) check(bus_rdata, exp_read(a, w), tag);
        else check(bus_rdata, 32'h0, {tag, " R12 idle"});
        @(posedge clk);
        mk = w ? d : {16'h0, d[15:0]};
        if (pwe) m_in = pdata;
        m_pend = (m_pend & ~((en && wr && !a[11] && a[7:4] == 4'h2) ? mk : 32'h0)) | pset;
        m_post = (m_post & ~pclr) | ((en && wr && !a[11] && a[7:4] == 4'h3) ? mk : 32'h0);
        if (en && wr && !a[11] && a[7:4] == 4'h1) m_out = w ? d : {m_out[31:16], d[15:0]};
        if (en && wr && !a[11] && a[7:4] == 4'h4) m_ctrl = ctrl_next(m_ctrl, d);
        #1;
        bus_en = 1'b0; peer_mbox_we = 1'b0; peer_flag_set = '0; peer_ack_clr = '0;
    endtask

    task automatic rd(input logic w, input logic [11:0] a, input string tag);
        cyc(1'b1, 1'b0, w, a, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, tag);
    endtask

    task automatic wr(input logic w, input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, w, a, d, 1'b0, 32'h0, 32'h0, 32'h0, tag);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        m_in = 0; m_out = 0; m_pend = 0; m_post = 0; m_ctrl = 0;
        seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b1, 12'h040, "R1 ctrl32");
        check(exp_read(12'h040, 1'b1), 32'hF000_0002, "R1 ctrl32 literal");
        rd(1'b0, 12'h040, "R1 ctrl16");
        rd(1'b1, 12'h000, "R1 inbox");
        rd(1'b1, 12'h010, "R1 outbox");
        rd(1'b1, 12'h020, "R1 pend");
        rd(1'b1, 12'h030, "R1 post");

        // R2 peer writes inbox, local write ignored
        cyc(1'b0, 1'b0, 1'b1, 12'h0, 32'h0, 1'b1, 32'hCAFE_0001, 32'h0, 32'h0, "R2 peer");
        wr(1'b1, 12'h000, 32'h1111_2222, "R2 local");
        rd(1'b1, 12'h000, "R2 inbox unchanged");

        // R3 / R11 outbox direct and half
        wr(1'b1, 12'h010, 32'hA5A5_5A5A, "R3 write");
        rd(1'b1, 12'h010, "R3 read");
        wr(1'b0, 12'h012, 32'hFFFF_1234, "R11 half write");
        rd(1'b1, 12'h010, "R11 upper kept");
        rd(1'b0, 12'h010, "R11 half read");

        // R4 pending flags: peer raises, local clears, tie
        cyc(1'b0, 1'b0, 1'b1, 12'h0, 32'h0, 1'b0, 32'h0, 32'hF0F0_00FF, 32'h0, "R4 raise");
        wr(1'b1, 12'h020, 32'h1000_000F, "R4 clear");
        rd(1'b1, 12'h020, "R4 after clear");
        cyc(1'b1, 1'b1, 1'b1, 12'h020, 32'h0000_0030, 1'b0, 32'h0, 32'h0000_0010, 32'h0, "R4 tie");
        rd(1'b1, 12'h020, "R4 set wins");

        // R5 posted flags: local sets, peer acks, tie
        wr(1'b1, 12'h030, 32'h8000_0101, "R5 set");
        cyc(1'b1, 1'b1, 1'b1, 12'h030, 32'h0000_0002, 1'b0, 32'h0, 32'h0, 32'h0000_0003, "R5 tie");
        rd(1'b1, 12'h030, "R5 local wins");
        check(exp_read(12'h030, 1'b1), 32'h8000_0102, "R5 literal");

        // R6 / R7 / R8 control sequence
        wr(1'b1, 12'h040, 32'h0000_0030, "R6 force+set");
        rd(1'b1, 12'h040, "R6 read");
        check(exp_read(12'h040, 1'b1), 32'hF000_2032, "R6 literal");
        wr(1'b1, 12'h040, 32'h0000_0010, "R7 clear");
        wr(1'b1, 12'h040, 32'hFFFF_0F4F, "R7 set bit6");
        rd(1'b1, 12'h040, "R7 read");
        check(exp_read(12'h040, 1'b1), 32'hF000_2062, "R7 literal");
        rd(1'b0, 12'h040, "R8 ctrl16");

        // R9 zero slot
        wr(1'b1, 12'h060, 32'hFFFF_FFFF, "R9 write");
        rd(1'b1, 12'h060, "R9 read");
        rd(1'b1, 12'h010, "R9 others kept");

        // R10 aliasing and unmapped
        rd(1'b1, 12'h71C, "R10 alias outbox");
        wr(1'b1, 12'h810, 32'h0BAD_0BAD, "R10 bit11 write");
        rd(1'b1, 12'h810, "R10 bit11 read");
        rd(1'b1, 12'h010, "R10 outbox kept");
        wr(1'b1, 12'h050, 32'h1234_5678, "R10 hole write");
        rd(1'b1, 12'h050, "R10 hole read");
        rd(1'b1, 12'h070, "R10 hole70 read");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [11:0] a;
            logic en, w_r, w;
            logic [31:0] d, ps, pc;
            a = {($urandom % 8 == 0), 3'($urandom), 4'($urandom % 8), 4'($urandom)};
            en = ($urandom % 4) != 0;
            w_r = $urandom % 2;
            w = $urandom % 2;
            d = $urandom;
            ps = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
            pc = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
            cyc(en, w_r, w, a, d, ($urandom % 5 == 0), $urandom, ps, pc, "R12 random");
        end
        for (int k = 0; k < 8; k++) rd(1'b1, 12'(k << 4), "R12 final sweep");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule